// File: doc/BRIEF.md
# Calendar Clock Core with Indexed Register Access

This block keeps wall-clock time (seconds, minutes, hours, day of week, day of month, month and a two-digit year) inside a small register file. A host reaches it through two byte ports: it first writes a register number to the index port, then reads or writes the selected byte on the data port. Time advances by one second each time an external prescaler delivers a one-cycle `tick_1hz` pulse.

The stored bytes follow the format the host selects in the control register: packed BCD or plain binary, and a 24-hour or a 12-hour clock with an afternoon marker in the top bit of the hour byte. Each tick first raises an update-busy flag for a fixed number of clock cycles. The counters change on the edge where that flag drops. A freeze bit in the control register stops all updates while the host loads new values. A status bit reports whether supply power has stayed valid.

Top module: `rtc_calendar_core`

## Requirements
- R1: A write with `bus_port`=0 loads bits 6:0 of `bus_wdata` as the register number, and bit 7 is discarded. A write with `bus_port`=1 stores the byte in the selected register. `bus_rdata` always shows the selected register. Register numbers: 0 seconds, 2 minutes, 4 hours, 6 weekday, 7 day of month, 8 month, 9 year, 10 status (bit 7 busy, read-only), 11 control (bit 7 freeze, bit 2 binary, bit 1 24-hour), 13 power status (bit 7 valid). Any other number reads 0x00 and ignores writes.
- R2: After reset the time is 00:00:00, weekday 1, day 1, month 1, year 0. Control reads 0x02 (BCD, 24-hour). Status reads 0x00 and power status reads 0x80.
- R3: A tick sampled while idle and not frozen sets the busy flag on that edge. The flag stays set for UIP_LEAD_CYCLES cycles, and the time advances by exactly one second on the edge where it clears. Ticks that arrive while it is set are ignored.
- R4: Seconds wrap from 59 to 0 into minutes, and minutes wrap from 59 to 0 into hours. In BCD mode each digit pair is packed (9 seconds → 0x09, 10 seconds → 0x10).
- R5: In 24-hour mode, hour 23 wraps to 0. The day change advances the weekday, with 7 wrapping to 1, and advances the day of month.
- R6: April, June, September and November have 30 days, and the other months have 31. February has 29 days when the year is divisible by 4 and 28 days otherwise.
- R7: Day 31 of month 12 rolls over to day 1 of month 1 and advances the year. Year 99 wraps to 0.
- R8: With control bit 2 set, all time fields are counted in plain binary (58 → 0x3B → 0x00 with a minute carry).
- R9: With control bit 1 clear, hours run 12, 1 … 11, and bit 7 of the hour byte marks PM. 11 AM rolls to 12 PM (0x92 in BCD). 12 PM rolls to 1 PM (0x81). 11 PM (0x91) rolls to 12 AM (0x12), which is the day change.
- R10: While the freeze bit is set, ticks are ignored and the busy flag stays low. Setting the freeze bit during a busy window cancels that update.
- R11: Power-status bit 7 clears whenever `power_good` is low. A data write to register 13 while `power_good` is high sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| power_good | input | 1 | High while supply power is valid |
| bus_wr | input | 1 | Host write strobe |
| bus_port | input | 1 | 0 selects the index port, 1 the data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Contents of the selected register |

## Verification
The bench builds the core with UIP_LEAD_CYCLES set to 4, so every busy window is short. This lets a single test edit the freeze bit inside an open window and also fire a second tick while the window is still open. With this short window the bench can also sample the seconds register on the last busy cycle and on the cycle after it, which pins down the exact edge on which the time changes. The calendar corners (leap and common Februaries, 30-day months, year 99) are reached directly, because the host loads the time just below each boundary and then sends one tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned IDX_W = 7;

  localparam logic [IDX_W-1:0] RI_SEC  = 7'd0;
  localparam logic [IDX_W-1:0] RI_MIN  = 7'd2;
  localparam logic [IDX_W-1:0] RI_HOUR = 7'd4;
  localparam logic [IDX_W-1:0] RI_WDAY = 7'd6;
  localparam logic [IDX_W-1:0] RI_MDAY = 7'd7;
  localparam logic [IDX_W-1:0] RI_MON  = 7'd8;
  localparam logic [IDX_W-1:0] RI_YEAR = 7'd9;
  localparam logic [IDX_W-1:0] RI_STAT = 7'd10;
  localparam logic [IDX_W-1:0] RI_CTRL = 7'd11;
  localparam logic [IDX_W-1:0] RI_PWR  = 7'd13;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  function automatic logic [6:0] field_dec(input logic [7:0] v, input logic bin);
    logic [6:0] hi;
    hi = {3'b000, v[7:4]};
    if (bin) return v[6:0];
    return hi * 7'd10 + {3'b000, v[3:0]};
  endfunction

  function automatic logic [7:0] field_enc(input logic [6:0] b, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = b / 7'd10;
    ones = b % 7'd10;
    if (bin) return {1'b0, b};
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                       return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int unsigned UIP_LEAD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic freeze,
  output logic uip,
  output logic do_update
);
  localparam int unsigned CW = $clog2(UIP_LEAD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(UIP_LEAD_CYCLES - 1);

  logic          uip_q, uip_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    uip_d     = uip_q;
    cnt_d     = cnt_q;
    do_update = 1'b0;
    if (freeze) begin
      uip_d = 1'b0;
      cnt_d = '0;
    end else if (uip_q) begin
      if (cnt_q == '0) begin
        do_update = 1'b1;
        uip_d     = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (tick) begin
      uip_d = 1'b1;
      cnt_d = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uip_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      uip_q <= uip_d;
      cnt_q <= cnt_d;
    end
  end

  assign uip = uip_q;

  assert_busy_low_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !uip_q);
  assert_busy_starts_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_q) |-> $past(tick && !freeze));
  assert_update_ends_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_update |=> !uip_q);

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      bin_mode,
  input  logic      h24_mode,
  output rtc_time_t nxt
);
  logic [6:0] s, m, hraw, h, wd, d, mo, y, dim;
  logic [6:0] s_n, m_n, h_n, wd_n, d_n, mo_n, y_n, h12;
  logic       pm, c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] h12_enc;

  always_comb begin
    s    = field_dec(cur.sec, bin_mode);
    m    = field_dec(cur.min, bin_mode);
    hraw = field_dec({1'b0, cur.hour[6:0]}, bin_mode);
    pm   = cur.hour[7];
    wd   = field_dec(cur.wday, bin_mode);
    d    = field_dec(cur.mday, bin_mode);
    mo   = field_dec(cur.mon, bin_mode);
    y    = field_dec(cur.year, bin_mode);

    if (h24_mode)          h = hraw;
    else if (hraw == 7'd12) h = pm ? 7'd12 : 7'd0;
    else                   h = hraw + (pm ? 7'd12 : 7'd0);

    dim = month_days(mo, y);

    c_min = (s >= 7'd59);
    s_n   = c_min ? 7'd0 : s + 7'd1;
    c_hr  = c_min && (m >= 7'd59);
    m_n   = c_min ? ((m >= 7'd59) ? 7'd0 : m + 7'd1) : m;
    c_day = c_hr && (h >= 7'd23);
    h_n   = c_hr ? ((h >= 7'd23) ? 7'd0 : h + 7'd1) : h;
    wd_n  = c_day ? ((wd >= 7'd7) ? 7'd1 : wd + 7'd1) : wd;
    c_mon = c_day && (d >= dim);
    d_n   = c_day ? ((d >= dim) ? 7'd1 : d + 7'd1) : d;
    c_yr  = c_mon && (mo >= 7'd12);
    mo_n  = c_mon ? ((mo >= 7'd12) ? 7'd1 : mo + 7'd1) : mo;
    y_n   = c_yr ? ((y >= 7'd99) ? 7'd0 : y + 7'd1) : y;

    h12 = (h_n >= 7'd12) ? h_n - 7'd12 : h_n;
    if (h12 == 7'd0) h12 = 7'd12;
    h12_enc = field_enc(h12, bin_mode);

    nxt.sec  = field_enc(s_n, bin_mode);
    nxt.min  = field_enc(m_n, bin_mode);
    nxt.hour = h24_mode ? field_enc(h_n, bin_mode) : {(h_n >= 7'd12), h12_enc[6:0]};
    nxt.wday = field_enc(wd_n, bin_mode);
    nxt.mday = field_enc(d_n, bin_mode);
    nxt.mon  = field_enc(mo_n, bin_mode);
    nxt.year = field_enc(y_n, bin_mode);
  end

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  rtc_time_t        tm,
  input  logic             uip,
  input  logic             set_bit,
  input  logic             bin_mode,
  input  logic             h24_mode,
  input  logic             pwr_valid,
  output logic [7:0]       rdata
);
  always_comb begin
    case (idx)
      RI_SEC:  rdata = tm.sec;
      RI_MIN:  rdata = tm.min;
      RI_HOUR: rdata = tm.hour;
      RI_WDAY: rdata = tm.wday;
      RI_MDAY: rdata = tm.mday;
      RI_MON:  rdata = tm.mon;
      RI_YEAR: rdata = tm.year;
      RI_STAT: rdata = {uip, 7'b0};
      RI_CTRL: rdata = {set_bit, 4'b0, bin_mode, h24_mode, 1'b0};
      RI_PWR:  rdata = {pwr_valid, 7'b0};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int unsigned UIP_LEAD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       power_good,
  input  logic       bus_wr,
  input  logic       bus_port,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                                      mday: 8'h01, mon: 8'h01, year: 8'h00};

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [IDX_W-1:0] idx_q, idx_d;
  rtc_time_t        tm_q, tm_d, tm_adv;
  logic             set_q, set_d, bin_q, bin_d, h24_q, h24_d, vrt_q, vrt_d;
  logic             uip, do_update, idx_wr, data_wr, time_wr;

  assign idx_wr  = bus_wr && !bus_port;
  assign data_wr = bus_wr && bus_port;

  rtc_update_seq #(.UIP_LEAD_CYCLES(UIP_LEAD_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_i_n), .tick(tick_1hz), .freeze(set_q),
    .uip(uip), .do_update(do_update)
  );

  rtc_advance adv_i (
    .cur(tm_q), .bin_mode(bin_q), .h24_mode(h24_q), .nxt(tm_adv)
  );

  rtc_read_mux mux_i (
    .idx(idx_q), .tm(tm_q), .uip(uip), .set_bit(set_q), .bin_mode(bin_q),
    .h24_mode(h24_q), .pwr_valid(vrt_q), .rdata(bus_rdata)
  );

  always_comb begin
    idx_d   = idx_wr ? bus_wdata[IDX_W-1:0] : idx_q;
    tm_d    = do_update ? tm_adv : tm_q;
    set_d   = set_q;
    bin_d   = bin_q;
    h24_d   = h24_q;
    time_wr = 1'b0;
    if (data_wr) begin
      case (idx_q)
        RI_SEC:  begin tm_d.sec  = bus_wdata; time_wr = 1'b1; end
        RI_MIN:  begin tm_d.min  = bus_wdata; time_wr = 1'b1; end
        RI_HOUR: begin tm_d.hour = bus_wdata; time_wr = 1'b1; end
        RI_WDAY: begin tm_d.wday = bus_wdata; time_wr = 1'b1; end
        RI_MDAY: begin tm_d.mday = bus_wdata; time_wr = 1'b1; end
        RI_MON:  begin tm_d.mon  = bus_wdata; time_wr = 1'b1; end
        RI_YEAR: begin tm_d.year = bus_wdata; time_wr = 1'b1; end
        RI_CTRL: begin
          set_d = bus_wdata[7];
          bin_d = bus_wdata[2];
          h24_d = bus_wdata[1];
        end
        default: ;
      endcase
    end
    if (!power_good)                          vrt_d = 1'b0;
    else if (data_wr && idx_q == RI_PWR)      vrt_d = 1'b1;
    else                                      vrt_d = vrt_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      idx_q <= '0;
      tm_q  <= TIME_RST;
      set_q <= 1'b0;
      bin_q <= 1'b0;
      h24_q <= 1'b1;
      vrt_q <= 1'b1;
    end else begin
      idx_q <= idx_d;
      tm_q  <= tm_d;
      set_q <= set_d;
      bin_q <= bin_d;
      h24_q <= h24_d;
      vrt_q <= vrt_d;
    end
  end

  assert_time_held_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!do_update && !time_wr) |=> $stable(tm_q));
  assert_pwr_flag_drops_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !power_good |=> !vrt_q);
  assert_no_update_frozen_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    set_q |-> !do_update);
  assert_time_only_moves_at_window_end_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (do_update && !time_wr) |-> $past(uip));

endmodule

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
  localparam int unsigned LEAD = 4;

  logic       clk, rst_n, tick_1hz, power_good, bus_wr, bus_port;
  logic [7:0] bus_wdata, bus_rdata;
  int         n_chk, n_fail;
  bit         done;

  rtc_calendar_core #(.UIP_LEAD_CYCLES(LEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .power_good(power_good),
    .bus_wr(bus_wr), .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] i);
    bus_port = 1'b0; bus_wdata = i; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    bus_port = 1'b1; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    wr_idx(i);
    wr_data(v);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] i, input logic [7:0] exp);
    wr_idx(i);
    check(tag, bus_rdata, exp);
  endtask

  task automatic load_time(input logic [7:0] s, mi, h, wd, d, mo, y);
    wr_reg(8'd0, s); wr_reg(8'd2, mi); wr_reg(8'd4, h); wr_reg(8'd6, wd);
    wr_reg(8'd7, d); wr_reg(8'd8, mo); wr_reg(8'd9, y);
  endtask

  task automatic one_tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    repeat (LEAD) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R2 sec", 8'd0, 8'h00);
    rd_chk("R2 hour", 8'd4, 8'h00);
    rd_chk("R2 wday", 8'd6, 8'h01);
    rd_chk("R2 mday", 8'd7, 8'h01);
    rd_chk("R2 mon", 8'd8, 8'h01);
    rd_chk("R2 year", 8'd9, 8'h00);
    rd_chk("R2 ctrl", 8'd11, 8'h02);
    rd_chk("R2 stat", 8'd10, 8'h00);
    rd_chk("R2 pwr", 8'd13, 8'h80);
  endtask

  task automatic t_index();
    wr_idx(8'h87);
    wr_data(8'h15);
    check("R1 idx bit7 dropped", bus_rdata, 8'h15);
    wr_reg(8'd3, 8'h55);
    check("R1 unmapped reads 0", bus_rdata, 8'h00);
    wr_reg(8'd10, 8'hFF);
    check("R1 status read-only", bus_rdata, 8'h00);
  endtask

  task automatic t_busy();
    load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr_idx(8'd10);
    tick_1hz = 1'b1;
    @(negedge clk);
    check("R3 busy after tick", bus_rdata, 8'h80);
    @(negedge clk);
    tick_1hz = 1'b0;
    repeat (LEAD - 1) @(negedge clk);
    check("R3 busy cleared", bus_rdata, 8'h00);
    rd_chk("R3 single advance", 8'd0, 8'h01);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    repeat (LEAD - 1) @(negedge clk);
    check("R3 sec before window end", bus_rdata, 8'h01);
    @(negedge clk);
    check("R3 sec at window end", bus_rdata, 8'h02);
  endtask

  task automatic t_carry();
    load_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    one_tick();
    rd_chk("R4 bcd 9 to 10", 8'd0, 8'h10);
    load_time(8'h59, 8'h59, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    one_tick();
    rd_chk("R4 sec wrap", 8'd0, 8'h00);
    rd_chk("R4 min wrap", 8'd2, 8'h00);
    rd_chk("R4 hour carry", 8'd4, 8'h01);
  endtask

  task automatic t_day();
    load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h10);
    one_tick();
    rd_chk("R5 hour wrap", 8'd4, 8'h00);
    rd_chk("R5 wday wrap", 8'd6, 8'h01);
    rd_chk("R5 mday inc", 8'd7, 8'h16);
  endtask

  task automatic t_months();
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
    one_tick();
    rd_chk("R6 april 30 day", 8'd7, 8'h01);
    rd_chk("R6 april 30 mon", 8'd8, 8'h05);
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h21);
    one_tick();
    rd_chk("R6 january 31", 8'd7, 8'h31);
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    one_tick();
    rd_chk("R6 common feb mon", 8'd8, 8'h03);
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    one_tick();
    rd_chk("R6 leap feb 29", 8'd7, 8'h29);
    one_tick();
    rd_chk("R6 leap feb 29 holds", 8'd7, 8'h29);
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    one_tick();
    rd_chk("R6 leap feb end day", 8'd7, 8'h01);
    rd_chk("R6 leap feb end mon", 8'd8, 8'h03);
  endtask

  task automatic t_year();
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h19);
    one_tick();
    rd_chk("R7 year bcd inc", 8'd9, 8'h20);
    rd_chk("R7 month wrap", 8'd8, 8'h01);
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    one_tick();
    rd_chk("R7 year 99 wrap", 8'd9, 8'h00);
    rd_chk("R7 day 1", 8'd7, 8'h01);
  endtask

  task automatic t_binary();
    wr_reg(8'd11, 8'h06);
    load_time(8'h3A, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    one_tick();
    rd_chk("R8 binary 59", 8'd0, 8'h3B);
    one_tick();
    rd_chk("R8 binary sec wrap", 8'd0, 8'h00);
    rd_chk("R8 binary min carry", 8'd2, 8'h01);
    wr_reg(8'd11, 8'h02);
  endtask

  task automatic t_12h();
    wr_reg(8'd11, 8'h00);
    load_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h05, 8'h20);
    one_tick();
    rd_chk("R9 11am to 12pm", 8'd4, 8'h92);
    load_time(8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h05, 8'h20);
    one_tick();
    rd_chk("R9 12pm to 1pm", 8'd4, 8'h81);
    load_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h05, 8'h20);
    one_tick();
    rd_chk("R9 11pm to 12am", 8'd4, 8'h12);
    rd_chk("R9 midnight wday", 8'd6, 8'h03);
    rd_chk("R9 midnight mday", 8'd7, 8'h11);
    load_time(8'h59, 8'h59, 8'h12, 8'h02, 8'h10, 8'h05, 8'h20);
    one_tick();
    rd_chk("R9 12am to 1am", 8'd4, 8'h01);
    wr_reg(8'd11, 8'h02);
  endtask

  task automatic t_freeze();
    load_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr_reg(8'd11, 8'h82);
    wr_idx(8'd10);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    check("R10 no busy when frozen", bus_rdata, 8'h00);
    repeat (LEAD + 1) @(negedge clk);
    rd_chk("R10 frozen sec held", 8'd0, 8'h05);
    wr_reg(8'd11, 8'h02);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    wr_data(8'h82);
    repeat (LEAD + 2) @(negedge clk);
    rd_chk("R10 cancelled update", 8'd0, 8'h05);
    wr_reg(8'd11, 8'h02);
  endtask

  task automatic t_power();
    wr_idx(8'd13);
    power_good = 1'b0;
    @(negedge clk);
    power_good = 1'b1;
    @(negedge clk);
    check("R11 flag cleared", bus_rdata, 8'h00);
    wr_data(8'h00);
    check("R11 flag rearmed", bus_rdata, 8'h80);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; tick_1hz = 1'b0; power_good = 1'b1;
    bus_wr = 1'b0; bus_port = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_index();
    t_busy();
    t_carry();
    t_day();
    t_months();
    t_year();
    t_binary();
    t_12h();
    t_freeze();
    t_power();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule